// File: doc/BRIEF.md
# Asynchronous-Strobe 16-bit Bus Slave

This block connects a 16-bit strobe-based external bus with an acknowledge handshake to an internal register or memory port, and runs entirely on the bus clock. The bus control inputs are chip select, address strobe, upper and lower data strobes and read/write. They pass through a two-flop synchronizer. A bus cycle begins on the first clock edge at which the synchronized chip select, address strobe and at least one data strobe are all low. At that edge the block latches the address, the space select (memory or register) and the divider setting.

The acknowledge is a wait count taken from a table indexed by the memory-clock divider setting (divide by 1, 2, 3 or 4). The acknowledge output has its own output enable. It is driven high while the cycle waits, pulled low when the count expires, and returned high for one clock before release after the address strobe rises. Write data is captured into a buffer on the third active edge and is committed to the internal port only when the acknowledge is issued. Only the strobed byte lanes are committed. On a read, the internal read data is registered as the acknowledge is issued, and both lanes are driven while a data strobe stays low. If the address strobe rises before the acknowledge, the cycle is abandoned with no write.

Top module: `bus68_slave`

## Requirements
- R1: The acknowledge (dtack_no_o low) appears on the edge that is LAT edges after the cycle start, counting the start edge as the first. LAT is 8, 13, 17 or 23 for div_sel_i = 0, 1, 2, 3. Seen from the raw pins, with the first edge that samples the strobes low counted as edge 1, it appears after edge LAT+2.
- R2: A cycle starts only when cs_ni, as_ni and at least one of uds_ni/lds_ni are sampled low after the two-flop synchronizer. If both data strobes stay high, no cycle starts and dtack_oe_o stays 0.
- R3: From the start edge until the acknowledge, dtack_oe_o is 1 and dtack_no_o is 1.
- R4: On a write, data_i is captured on the third active edge (the start edge is the first). Changes to data_i after that edge do not alter the committed data.
- R5: A write is committed as a one-cycle mem_we_o pulse that coincides with the acknowledge. mem_be_o is {~uds, ~lds} as sampled at start: bit 1 is D[15:8] and bit 0 is D[7:0].
- R6: On a read (rw_i = 1), data_o holds the mem_rdata_i value registered as the acknowledge is issued. data_oe_o is 1 while the synchronized data strobes are not both high, and it drives both lanes.
- R7: After the synchronized address strobe is seen high following an acknowledge, dtack_no_o returns to 1 with dtack_oe_o still 1 for one cycle, and dtack_oe_o then drops to 0.
- R8: If the address strobe rises before the acknowledge, the cycle returns to idle with no mem_we_o pulse and no acknowledge.
- R9: div_sel_i is sampled only at the start edge. Changing it mid-cycle does not alter that cycle's latency.
- R10: mem_addr_o and mem_space_o hold the addr_i and mr_i values sampled at the start edge for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| as_ni | input | 1 | Address strobe, active low |
| uds_ni | input | 1 | Upper data strobe (D[15:8]), active low |
| lds_ni | input | 1 | Lower data strobe (D[7:0]), active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| mr_i | input | 1 | Space select: memory or register |
| addr_i | input | 16 | Word address A[16:1] |
| div_sel_i | input | 2 | Memory-clock divider setting 0..3 (÷1..÷4) |
| data_i | input | 16 | Bus data in |
| data_o | output | 16 | Bus data out |
| data_oe_o | output | 1 | Data bus output enable |
| dtack_no_o | output | 1 | Acknowledge, active low |
| dtack_oe_o | output | 1 | Acknowledge output enable |
| mem_addr_o | output | 16 | Internal port address |
| mem_space_o | output | 1 | Internal port space select |
| mem_we_o | output | 1 | Internal write strobe |
| mem_be_o | output | 2 | Internal byte enables |
| mem_wdata_o | output | 16 | Internal write data |
| mem_re_o | output | 1 | Internal read strobe |
| mem_rdata_i | input | 16 | Internal read data |

## Verification
Two events can fall on the same edge: the address strobe rising, which ends or aborts a cycle, and the latency counter expiring, which acknowledges the cycle. The bench drives abort cycles that release the strobe a few clocks into the wait, and it also places releases close to the expiry point. An abort must leave no write pulse and no acknowledge, and in the design the abort takes priority over the expiry. The bench also changes data_i and div_sel_i mid-cycle. It judges that the committed word and the latency keep the values sampled at the capture edge and the start edge.

// File: rtl/bus68_pkg.sv
package bus68_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK, ST_DONE} bus_st_e;
endpackage

// File: rtl/bus68_sync.sv
module bus68_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/bus68_lat_cnt.sv
module bus68_lat_cnt #(
  parameter int unsigned LAT0 = 8,
  parameter int unsigned LAT1 = 13,
  parameter int unsigned LAT2 = 17,
  parameter int unsigned LAT3 = 23,
  parameter int unsigned CAP_EDGE = 3,
  localparam int unsigned LMAX = (LAT3 > LAT2) ? ((LAT3 > LAT1) ? LAT3 : LAT1) : LAT2,
  localparam int unsigned CW = $clog2(LMAX + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       run_i,
  input  logic [1:0] div_i,
  output logic       cap_o,
  output logic       hit_o
);
  logic [CW-1:0] lat_q, cnt_q, lat_sel;

  always_comb begin
    unique case (div_i)
      2'd0: lat_sel = CW'(LAT0);
      2'd1: lat_sel = CW'(LAT1);
      2'd2: lat_sel = CW'(LAT2);
      default: lat_sel = CW'(LAT3);
    endcase
  end

  // divider captured only on start: mid-cycle changes are ignored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= CW'(LAT0);
      cnt_q <= '0;
    end else if (start_i) begin
      lat_q <= lat_sel;
      cnt_q <= CW'(1);
    end else if (run_i && cnt_q < lat_q) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign cap_o = run_i && (cnt_q == CW'(CAP_EDGE - 1));
  assign hit_o = run_i && (cnt_q == lat_q - CW'(1));

  p_div_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i) |=> $stable(lat_q));
endmodule

// File: rtl/bus68_lanes.sv
module bus68_lanes #(
  parameter int unsigned DW = 16,
  localparam int unsigned NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cap_i,
  input  logic [NB-1:0] ds_ni,
  input  logic [DW-1:0] data_i,
  output logic [NB-1:0] be_o,
  output logic [DW-1:0] wbuf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) be_o <= '0;
    else if (start_i) be_o <= ~ds_ni;
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wbuf_o[8*b +: 8] <= '0;
      else if (cap_i) wbuf_o[8*b +: 8] <= data_i[8*b +: 8];
    end
  end
endmodule

// File: rtl/bus68_slave.sv
module bus68_slave
  import bus68_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned LAT0 = 8,
  parameter int unsigned LAT1 = 13,
  parameter int unsigned LAT2 = 17,
  parameter int unsigned LAT3 = 23
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          as_ni,
  input  logic          uds_ni,
  input  logic          lds_ni,
  input  logic          rw_i,
  input  logic          mr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    div_sel_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          dtack_no_o,
  output logic          dtack_oe_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_space_o,
  output logic          mem_we_o,
  output logic [1:0]    mem_be_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_re_o,
  input  logic [DW-1:0] mem_rdata_i
);
  logic [3:0] ctl_s;
  logic cs_s, as_s, uds_s, lds_s;
  bus_st_e st_q, st_d;
  logic go, run, lat_cap, lat_hit, rd_q;

  bus68_sync #(.W(4), .RST_VAL(4'hF)) u_sync (
    .clk_i, .rst_ni,
    .d_i({cs_ni, as_ni, uds_ni, lds_ni}),
    .q_o(ctl_s)
  );
  assign {cs_s, as_s, uds_s, lds_s} = ctl_s;

  assign go  = (st_q == ST_IDLE) && !cs_s && !as_s && !(uds_s && lds_s);
  assign run = (st_q == ST_WAIT);

  bus68_lat_cnt #(.LAT0(LAT0), .LAT1(LAT1), .LAT2(LAT2), .LAT3(LAT3)) u_lat (
    .clk_i, .rst_ni, .start_i(go), .run_i(run), .div_i(div_sel_i),
    .cap_o(lat_cap), .hit_o(lat_hit)
  );

  bus68_lanes #(.DW(DW)) u_lanes (
    .clk_i, .rst_ni, .start_i(go), .cap_i(lat_cap && !rd_q),
    .ds_ni({uds_ni, lds_ni}), .data_i,
    .be_o(mem_be_o), .wbuf_o(mem_wdata_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go) st_d = ST_WAIT;
      ST_WAIT: if (as_s) st_d = ST_DONE;      // abort wins over expiry
               else if (lat_hit) st_d = ST_ACK;
      ST_ACK:  if (as_s) st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      rd_q        <= 1'b0;
      mem_addr_o  <= '0;
      mem_space_o <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_re_o    <= 1'b0;
      data_o      <= '0;
    end else begin
      st_q     <= st_d;
      mem_we_o <= run && !as_s && lat_hit && !rd_q;
      mem_re_o <= go && rw_i;
      if (go) begin
        rd_q        <= rw_i;
        mem_addr_o  <= addr_i;
        mem_space_o <= mr_i;
      end
      if (run && !as_s && lat_hit && rd_q) data_o <= mem_rdata_i;
    end
  end

  assign dtack_no_o = (st_q != ST_ACK);
  assign dtack_oe_o = (st_q != ST_IDLE);
  assign data_oe_o  = rd_q && (st_q == ST_WAIT || st_q == ST_ACK) && !(uds_s && lds_s);

  p_ack_on_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dtack_no_o) |-> $past(lat_hit));
  p_drive_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dtack_no_o |-> dtack_oe_o);
  p_we_with_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !dtack_no_o);
  p_oe_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> rd_q);
  p_abort_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && as_s) |=> (dtack_no_o && !mem_we_o));
endmodule

// File: tb/bus68_slave_tb_top.sv
module bus68_slave_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1, as_ni = 1, uds_ni = 1, lds_ni = 1, rw_i = 0, mr_i = 0;
  logic [15:0] addr_i = '0, data_i = '0, mem_rdata_i;
  logic [1:0] div_sel_i = '0;
  logic [15:0] data_o, mem_addr_o, mem_wdata_o;
  logic data_oe_o, dtack_no_o, dtack_oe_o, mem_space_o, mem_we_o, mem_re_o;
  logic [1:0] mem_be_o;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  bus68_slave dut_i (.clk_i(clk), .*);

  function automatic logic [15:0] rd_model(logic [15:0] a, logic s);
    return (a * 16'd3) ^ (s ? 16'hC3A5 : 16'h5A0F);
  endfunction
  function automatic int lat_of(logic [1:0] d);
    case (d) 2'd0: return 8; 2'd1: return 13; 2'd2: return 17; default: return 23; endcase
  endfunction
  assign mem_rdata_i = rd_model(mem_addr_o, mem_space_o);

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic release_bus();
    @(negedge clk);
    cs_ni = 1; as_ni = 1; uds_ni = 1; lds_ni = 1;
  endtask

  // abort_n = 0: full cycle; otherwise release AS after that many edges
  task automatic bus_cycle(bit rd, logic [1:0] div, logic u, logic l,
                           logic [15:0] a, logic s, logic [15:0] d, int abort_n);
    int n = 0;
    int lat = lat_of(div);
    bit seen_ack = 0, seen_we = 0;
    @(negedge clk);
    rw_i = rd; div_sel_i = div; addr_i = a; mr_i = s; data_i = d;
    cs_ni = 0; as_ni = 0; uds_ni = u; lds_ni = l;
    while (n < 60) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 4) chk(dtack_oe_o && dtack_no_o, "R3", {dtack_oe_o, dtack_no_o}, 2'b11);
      if (n == 5) begin data_i = ~d; div_sel_i = ~div; end
      if (n == 6) chk(mem_addr_o == a && mem_space_o == s, "R10", {mem_addr_o, 15'd0, mem_space_o}, {a, 15'd0, s});
      if (abort_n != 0) begin
        if (n == abort_n) begin cs_ni = 1; as_ni = 1; uds_ni = 1; lds_ni = 1; end
        if (!dtack_no_o) seen_ack = 1;
        if (mem_we_o) seen_we = 1;
        if (n == lat + 4) break;
      end else if (!dtack_no_o) break;
    end
    if (abort_n != 0) begin
      chk(!seen_ack && !seen_we && !dtack_oe_o, "R8", {seen_ack, seen_we, dtack_oe_o}, 0);
      return;
    end
    chk(n == lat + 2, "R1/R9", n, lat + 2);
    if (rd) begin
      chk(data_o == rd_model(a, s) && data_oe_o, "R6", data_o, rd_model(a, s));
    end else begin
      logic [15:0] m = {{8{~u}}, {8{~l}}};
      chk(mem_we_o && mem_be_o == {~u, ~l}, "R5", {mem_we_o, mem_be_o}, {1'b1, ~u, ~l});
      chk((mem_wdata_o & m) == (d & m), "R4", mem_wdata_o & m, d & m);
    end
    @(negedge clk);
    cs_ni = 1; as_ni = 1; uds_ni = 1; lds_ni = 1;
    chk(!mem_we_o, "R5", mem_we_o, 0);
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 1 && rd) chk(data_oe_o, "R6", data_oe_o, 1);
      if (k == 2) chk(!data_oe_o, "R6", data_oe_o, 0);
      if (k == 3) chk(dtack_oe_o && dtack_no_o, "R7", {dtack_oe_o, dtack_no_o}, 2'b11);
      if (k == 4) chk(!dtack_oe_o, "R7", dtack_oe_o, 0);
    end
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(!dtack_oe_o && !data_oe_o && !mem_we_o && dtack_no_o, "R2", {dtack_oe_o, data_oe_o, mem_we_o}, 0);
    // no data strobe: no cycle
    cs_ni = 0; as_ni = 0;
    repeat (10) @(negedge clk);
    chk(!dtack_oe_o, "R2", dtack_oe_o, 0);
    release_bus();
    repeat (4) @(negedge clk);
    for (int dv = 0; dv < 4; dv++) begin
      bus_cycle(0, 2'(dv), 0, 0, 16'h1000 + 16'(dv), dv[0], 16'hA55A ^ 16'(dv), 0);
      bus_cycle(1, 2'(dv), 0, 1, 16'h2000 + 16'(dv), dv[1], 16'h0, 0);
    end
    bus_cycle(0, 2'd0, 1, 0, 16'h0033, 0, 16'h12EF, 0);
    bus_cycle(0, 2'd3, 0, 1, 16'hFFFF, 1, 16'hBE00, 0);
    bus_cycle(0, 2'd0, 0, 0, 16'h0044, 0, 16'h7777, 5);
    bus_cycle(0, 2'd2, 0, 0, 16'h0045, 1, 16'h8888, 3);
    bus_cycle(0, 2'd0, 0, 0, 16'h0046, 0, 16'h9999, 7);
    for (int i = 0; i < 30; i++) begin
      logic [1:0] ds = 2'($urandom_range(0, 2));
      bus_cycle(1'($urandom), 2'($urandom), ds[1], ds[0], 16'($urandom), 1'($urandom),
                16'($urandom), ($urandom_range(0, 3) == 0) ? 4 : 0);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule